// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block takes a freshly powered SD card into SPI data-transfer mode. A single `start` pulse launches the sequence. The block does not drive the serial pins itself. It asks a separate command engine for two kinds of operation. The first is a burst of idle clock bytes (0xFF with chip select high). The second is a full command frame with its response. The engine answers each request with one `rsp_valid` pulse, which carries the first response byte (R1) and, for long responses, four more bytes.

The sequence has these steps:
- Send wake-up clocks.
- Reset the card until it reports idle.
- Probe the interface condition, and choose the older-card path or the newer-card path from the answer.
- Repeat the application initialisation command until the card leaves idle.
- On newer cards, read the operating-conditions register to learn whether the card is addressed by block (high capacity) or by byte.

Retry limits exist at two levels. A failing step counts against an inner limit. A failed attempt restarts the whole sequence from the reset command, and those restarts count against an outer limit.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, `done`, `error`, `high_cap` and `req_valid` are all low. A `start` pulse while idle begins a sequence.
- R2: The first request after `start` is an idle-clock request (`req_is_cmd`=0) with `req_idle_bytes`=WAKE_BYTES.
- R3: Every request is a one-cycle `req_valid` pulse. The next request is issued only after `rsp_valid`. Once a command's response arrives, the next request is an idle-clock request of exactly 1 byte.
- R4: The reset command has index 0, argument 0 and CRC byte 0x95. It is repeated until R1 equals 0x01, for at most IDLE_TRIES attempts. Success on the last allowed attempt counts.
- R5: The interface probe has index 8, argument 0x1AA, CRC byte 0x87 and `req_long`=1. If R1 bit 2 (0x04) is set, the older-card path is taken. If R1 equals 0x01, the newer-card path is taken. Any other R1 fails the attempt.
- R6: Older-card path: index 55 (argument 0, CRC 0xFF, its R1 ignored), then index 41 with argument 0. The pair repeats while R1 equals 0x01, for at most IDLE_TRIES pairs. Any other R1 ends the sequence with `done`=1 and `high_cap`=0.
- R7: Newer-card path: index 55, then index 41 with argument 0x40000000, repeated while R1 equals 0x01, for at most IDLE_TRIES pairs. If R1 bit 2 is set, the fallback loop is entered. Any other R1 goes to the register read.
- R8: Fallback loop: index 55 must return exactly 0x01, otherwise the attempt fails. Index 41 then uses argument 0 and repeats while R1 equals 0x01. Its pair count restarts from zero on entry to the loop.
- R9: Register read: index 58, argument 0, CRC 0xFF, `req_long`=1. R1 must be 0x00, otherwise the attempt fails. On success, `done`=1 and `high_cap` equals `rsp_payload[30]`, which is bit 6 of the first trailing byte. That byte occupies `rsp_payload[31:24]`.
- R10: A failed attempt restarts at the reset command without wake-up clocks. After SEQ_TRIES failed attempts, `error`=1 and no further request is made.
- R11: `done` and `error` are never high together. Both hold until the next `start`. A `start` during a running sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence (idle only) |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence gave up after all attempts |
| high_cap | output | 1 | Card uses block addressing (valid with done) |
| req_valid | output | 1 | One-cycle request to the command engine |
| req_is_cmd | output | 1 | 1: command frame, 0: idle clock bytes |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_crc | output | 8 | Final frame byte |
| req_long | output | 1 | Four response bytes follow R1 |
| req_idle_bytes | output | CNT_W | Idle byte count for idle-clock requests |
| rsp_valid | input | 1 | Request completed |
| rsp_r1 | input | 8 | First response byte |
| rsp_payload | input | 32 | Trailing response bytes, first byte in bits 31:24 |

## Verification
The assertions assume the engine answers each request with exactly one `rsp_valid` pulse. They also assume that pulse comes at least one cycle after the request and never without a request outstanding. The bench's responder enforces this: it holds a single pending reply and raises `rsp_valid` a fixed three cycles after each observed request. Card answers come from a script that pairs each expected request with its R1 and payload. Every response therefore corresponds to a request the model already accepted.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

   typedef enum logic [3:0] {
      ST_OFF, ST_WAKE, ST_RST, ST_IFC,
      ST_V1_APP, ST_V1_OP, ST_V2_APP, ST_V2_OP,
      ST_FB_APP, ST_FB_OP, ST_OCR
   } step_e;

   typedef enum logic [1:0] {
      PH_REST, PH_WAIT, PH_TAIL, PH_TAIL_WAIT
   } phase_e;

   localparam logic [7:0] R1_IDLE  = 8'h01;
   localparam logic [7:0] R1_READY = 8'h00;
   localparam int         R1_ILL_BIT = 2;
   localparam int         OCR_CAP_BIT = 30;

   typedef struct packed {
      logic        is_cmd;
      logic [5:0]  index;
      logic [31:0] arg;
      logic [7:0]  crc;
      logic        long_rsp;
   } cmd_t;

   function automatic cmd_t cmd_for(step_e s);
      case (s)
         ST_RST:                         return '{1'b1, 6'd0,  32'd0,         8'h95, 1'b0};
         ST_IFC:                         return '{1'b1, 6'd8,  32'h0000_01AA, 8'h87, 1'b1};
         ST_V1_APP, ST_V2_APP, ST_FB_APP: return '{1'b1, 6'd55, 32'd0,         8'hFF, 1'b0};
         ST_V1_OP, ST_FB_OP:             return '{1'b1, 6'd41, 32'd0,         8'hFF, 1'b0};
         ST_V2_OP:                       return '{1'b1, 6'd41, 32'h4000_0000, 8'hFF, 1'b0};
         ST_OCR:                         return '{1'b1, 6'd58, 32'd0,         8'hFF, 1'b1};
         default:                        return '{1'b0, 6'd0,  32'd0,         8'hFF, 1'b0};
      endcase
   endfunction

endpackage

// File: rtl/sd_init_retry.sv
module sd_init_retry #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sd_init_retry: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      logic unused_ctl;
      assign unused_ctl = clr ^ inc;
      assign last = 1'b1;
   end else begin : g_count
      localparam int W = $clog2(LIMIT);
      localparam logic [W-1:0] MAXV = W'(LIMIT - 1);
      logic [W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt <= '0;
         else if (clr)          cnt <= '0;
         else if (inc && !last) cnt <= cnt + 1'b1;
      end

      assign last = (cnt == MAXV);
   end

   // R4/R10: the sequencer never asks for another try once the limit is reached
   p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> !last);

endmodule

// File: rtl/sd_init_txn.sv
module sd_init_txn
   import sd_init_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic        go_cmd,
   input  logic        rsp_valid,
   input  logic [7:0]  rsp_r1,
   input  logic [31:0] rsp_payload,
   output logic        ready,
   output logic        req_fire,
   output logic        in_tail,
   output logic        fin,
   output logic [7:0]  r1_q,
   output logic [31:0] payload_q
);

   phase_e phase;
   logic   is_cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_REST;
         is_cmd_q  <= 1'b0;
         r1_q      <= 8'hFF;
         payload_q <= '0;
      end else begin
         unique case (phase)
            PH_REST: if (go) begin
               is_cmd_q <= go_cmd;
               phase    <= PH_WAIT;
            end
            PH_WAIT: if (rsp_valid) begin
               if (is_cmd_q) begin
                  r1_q      <= rsp_r1;
                  payload_q <= rsp_payload;
                  phase     <= PH_TAIL;
               end else begin
                  phase <= PH_REST;
               end
            end
            PH_TAIL:      phase <= PH_TAIL_WAIT;
            PH_TAIL_WAIT: if (rsp_valid) phase <= PH_REST;
            default:      phase <= PH_REST;
         endcase
      end
   end

   assign ready    = (phase == PH_REST);
   assign req_fire = ((phase == PH_REST) && go) || (phase == PH_TAIL);
   assign in_tail  = (phase == PH_TAIL);
   assign fin      = rsp_valid && (((phase == PH_WAIT) && !is_cmd_q) || (phase == PH_TAIL_WAIT));

   // R3: a command reply is always followed by the one-byte trailer request
   p_tail_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && is_cmd_q && rsp_valid) |=> (req_fire && in_tail));

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
   import sd_init_pkg::*;
#(
   parameter int WAKE_BYTES = 80,
   parameter int IDLE_TRIES = 100,
   parameter int SEQ_TRIES  = 128,
   localparam int CNT_W     = $clog2(WAKE_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             done,
   output logic             error,
   output logic             high_cap,
   output logic             req_valid,
   output logic             req_is_cmd,
   output logic [5:0]       req_index,
   output logic [31:0]      req_arg,
   output logic [7:0]       req_crc,
   output logic             req_long,
   output logic [CNT_W-1:0] req_idle_bytes,
   input  logic             rsp_valid,
   input  logic [7:0]       rsp_r1,
   input  logic [31:0]      rsp_payload
);

   if (WAKE_BYTES < 1) begin : g_bad_wake
      $error("sd_init_seq: WAKE_BYTES must be at least 1");
   end
   if (IDLE_TRIES < 1) begin : g_bad_idle
      $error("sd_init_seq: IDLE_TRIES must be at least 1");
   end
   if (SEQ_TRIES < 1) begin : g_bad_seq
      $error("sd_init_seq: SEQ_TRIES must be at least 1");
   end

   step_e       step, step_n;
   logic        done_n, err_n, hc_n;
   logic        in_clr, in_inc, in_last;
   logic        out_clr, out_inc, out_last;
   logic        bad;
   logic        txn_ready, txn_tail, fin;
   logic [7:0]  r1;
   logic [31:0] payload_q;
   cmd_t        cmd;

   assign cmd = cmd_for(step);

   sd_init_txn u_txn (
      .clk, .rst_n,
      .go          (step != ST_OFF && txn_ready),
      .go_cmd      (cmd.is_cmd),
      .rsp_valid, .rsp_r1, .rsp_payload,
      .ready       (txn_ready),
      .req_fire    (req_valid),
      .in_tail     (txn_tail),
      .fin,
      .r1_q        (r1),
      .payload_q
   );

   sd_init_retry #(.LIMIT(IDLE_TRIES)) u_inner (
      .clk, .rst_n, .clr(in_clr), .inc(in_inc), .last(in_last));

   sd_init_retry #(.LIMIT(SEQ_TRIES)) u_outer (
      .clk, .rst_n, .clr(out_clr), .inc(out_inc), .last(out_last));

   logic unused_payload;
   assign unused_payload = ^{payload_q[31], payload_q[29:0]};

   assign req_is_cmd     = txn_tail ? 1'b0 : cmd.is_cmd;
   assign req_index      = cmd.index;
   assign req_arg        = cmd.arg;
   assign req_crc        = cmd.crc;
   assign req_long       = cmd.long_rsp;
   assign req_idle_bytes = txn_tail ? CNT_W'(1) :
                           (step == ST_WAKE) ? CNT_W'(WAKE_BYTES) : '0;

   always_comb begin
      step_n  = step;
      done_n  = done;
      err_n   = error;
      hc_n    = high_cap;
      in_clr  = 1'b0;
      in_inc  = 1'b0;
      out_clr = 1'b0;
      out_inc = 1'b0;
      bad     = 1'b0;
      if (step == ST_OFF) begin
         if (start) begin
            step_n  = ST_WAKE;
            done_n  = 1'b0;
            err_n   = 1'b0;
            hc_n    = 1'b0;
            in_clr  = 1'b1;
            out_clr = 1'b1;
         end
      end else if (fin) begin
         unique case (step)
            ST_WAKE: step_n = ST_RST;
            ST_RST: begin
               if (r1 == R1_IDLE) begin
                  step_n = ST_IFC;
               end else if (in_last) bad = 1'b1;
               else in_inc = 1'b1;
            end
            ST_IFC: begin
               in_clr = 1'b1;
               if (r1[R1_ILL_BIT])     step_n = ST_V1_APP;
               else if (r1 == R1_IDLE) step_n = ST_V2_APP;
               else                    bad = 1'b1;
            end
            ST_V1_APP: step_n = ST_V1_OP;
            ST_V1_OP: begin
               if (r1 == R1_IDLE) begin
                  if (in_last) bad = 1'b1;
                  else begin in_inc = 1'b1; step_n = ST_V1_APP; end
               end else begin
                  step_n = ST_OFF;
                  done_n = 1'b1;
                  hc_n   = 1'b0;
               end
            end
            ST_V2_APP: step_n = ST_V2_OP;
            ST_V2_OP: begin
               if (r1 == R1_IDLE) begin
                  if (in_last) bad = 1'b1;
                  else begin in_inc = 1'b1; step_n = ST_V2_APP; end
               end else if (r1[R1_ILL_BIT]) begin
                  in_clr = 1'b1;
                  step_n = ST_FB_APP;
               end else step_n = ST_OCR;
            end
            ST_FB_APP: begin
               if (r1 != R1_IDLE) bad = 1'b1;
               else               step_n = ST_FB_OP;
            end
            ST_FB_OP: begin
               if (r1 == R1_IDLE) begin
                  if (in_last) bad = 1'b1;
                  else begin in_inc = 1'b1; step_n = ST_FB_APP; end
               end else step_n = ST_OCR;
            end
            ST_OCR: begin
               if (r1 == R1_READY) begin
                  step_n = ST_OFF;
                  done_n = 1'b1;
                  hc_n   = payload_q[OCR_CAP_BIT];
               end else bad = 1'b1;
            end
            default: step_n = ST_OFF;
         endcase
         if (bad) begin
            in_clr = 1'b1;
            in_inc = 1'b0;
            if (out_last) begin
               step_n = ST_OFF;
               err_n  = 1'b1;
            end else begin
               out_inc = 1'b1;
               step_n  = ST_RST;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step     <= ST_OFF;
         done     <= 1'b0;
         error    <= 1'b0;
         high_cap <= 1'b0;
      end else begin
         step     <= step_n;
         done     <= done_n;
         error    <= err_n;
         high_cap <= hc_n;
      end
   end

   // R3: requests are single-cycle pulses
   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   // R10: a finished or failed sequence makes no requests
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_OFF) |-> !req_valid);

   // R11: success and failure are exclusive
   p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   // R9: capacity flag is only reported with success
   p_cap_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      high_cap |-> done);

   // R11: completion is always triggered by an engine reply
   p_done_on_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rsp_valid));

endmodule

// File: tb/test_sd_init_seq.sv
`timescale 1ns/1ps
module test_sd_init_seq;

   localparam int WAKE = 80;
   localparam int TRIES = 4;
   localparam int ATTEMPTS = 3;
   localparam int CW = $clog2(WAKE + 1);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, start = 1'b0;
   logic done, error, high_cap;
   logic req_valid, req_is_cmd, req_long;
   logic [5:0] req_index;
   logic [31:0] req_arg;
   logic [7:0] req_crc;
   logic [CW-1:0] req_idle_bytes;
   logic rsp_valid = 1'b0;
   logic [7:0] rsp_r1 = 8'hFF;
   logic [31:0] rsp_payload = '0;

   sd_init_seq #(.WAKE_BYTES(WAKE), .IDLE_TRIES(TRIES), .SEQ_TRIES(ATTEMPTS)) i_sd_init_seq (
      .clk, .rst_n, .start, .done, .error, .high_cap,
      .req_valid, .req_is_cmd, .req_index, .req_arg, .req_crc, .req_long, .req_idle_bytes,
      .rsp_valid, .rsp_r1, .rsp_payload);

   int vectors = 0, fails = 0;
   string cur_tag = "R1";
   logic [54:0] exp_q[$];
   logic [39:0] rsp_q[$];
   bit model_busy = 0;
   int pend = 0;
   logic [39:0] pend_rsp;

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // expected request stream, paired with the card's scripted replies
   task automatic push_idle(int n);
      exp_q.push_back({1'b0, 6'd0, 32'd0, 8'd0, 1'b0, 7'(n)});
   endtask
   task automatic push_cmd(logic [5:0] idx, logic [31:0] arg, logic [7:0] crc, logic lng,
                           logic [7:0] r1, logic [31:0] ocr);
      exp_q.push_back({1'b1, idx, arg, crc, lng, 7'd0});
      rsp_q.push_back({r1, ocr});
      push_idle(1);   // R3 trailer byte
   endtask
   task automatic wake();                 push_idle(WAKE); endtask
   task automatic c0(logic [7:0] r1);     push_cmd(6'd0, 32'd0, 8'h95, 1'b0, r1, 32'd0); endtask
   task automatic c8(logic [7:0] r1);     push_cmd(6'd8, 32'h1AA, 8'h87, 1'b1, r1, 32'h1AA); endtask
   task automatic app(logic [7:0] r1);    push_cmd(6'd55, 32'd0, 8'hFF, 1'b0, r1, 32'd0); endtask
   task automatic op(logic [31:0] a, logic [7:0] r1); push_cmd(6'd41, a, 8'hFF, 1'b0, r1, 32'd0); endtask
   task automatic ocr(logic [7:0] r1, logic [31:0] v); push_cmd(6'd58, 32'd0, 8'hFF, 1'b1, r1, v); endtask

   // per-clock monitor and card responder
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(model_busy && (done || error)), {cur_tag, " R11 flags while busy"},
             {done, error}, 2'b00);
         rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               rsp_valid   = 1'b1;
               rsp_r1      = pend_rsp[39:32];
               rsp_payload = pend_rsp[31:0];
               if (exp_q.size() == 0) model_busy = 0;
            end
         end
         if (req_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " R10 unexpected request"}, req_index, 0);
            end else begin
               logic [54:0] e;
               e = exp_q.pop_front();
               if (e[54]) begin
                  chk({req_is_cmd, req_index, req_arg, req_crc, req_long} == e[54:7],
                      {cur_tag, " R3 command fields"},
                      {req_is_cmd, req_index, req_arg, req_crc, req_long}, e[54:7]);
                  pend_rsp = (rsp_q.size() != 0) ? rsp_q.pop_front() : 40'hFF_0000_0000;
               end else begin
                  chk({req_is_cmd, 7'(req_idle_bytes)} == {e[54], e[6:0]},
                      {cur_tag, " R2 idle request"},
                      {req_is_cmd, 7'(req_idle_bytes)}, {e[54], e[6:0]});
                  pend_rsp = 40'hFF_0000_0000;
               end
               pend = 3;
            end
         end
      end
   end

   task automatic run(string tag, logic ed, logic ee, logic eh, bit poke);
      cur_tag = tag;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0; model_busy = 1;
      if (poke) begin
         repeat (20) @(negedge clk);
         start = 1'b1;           // R11: ignored while running
         @(negedge clk); start = 1'b0;
      end
      for (int i = 0; i < 20000 && model_busy; i++) @(negedge clk);
      chk(!model_busy, {tag, " hung"}, model_busy, 0);
      model_busy = 0;
      repeat (3) @(negedge clk);
      chk(done == ed, {tag, " done"}, done, ed);
      chk(error == ee, {tag, " error (R10)"}, error, ee);
      chk(high_cap == eh, {tag, " high_cap (R9)"}, high_cap, eh);
      chk(exp_q.size() == 0, {tag, " leftover requests"}, exp_q.size(), 0);
      repeat (10) @(negedge clk);
      exp_q.delete(); rsp_q.delete();
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog R11: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 0, "R1 reset done", done, 0);
      chk(error == 0, "R1 reset error", error, 0);
      chk(high_cap == 0, "R1 reset high_cap", high_cap, 0);
      chk(req_valid == 0, "R1 reset req_valid", req_valid, 0);

      // R2 R4 R5 R7 R9: newer card, high capacity, stray start ignored
      wake(); c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h01);
      app(8'h01); op(32'h4000_0000, 8'h00); ocr(8'h00, 32'hC0FF_8000);
      run("R7", 1, 0, 1, 1);

      // R4 R6: reset succeeds on last allowed try, older card
      wake(); c0(8'hFF); c0(8'hFF); c0(8'hFF); c0(8'h01); c8(8'h05);
      app(8'h01); op(32'd0, 8'h01); app(8'h00); op(32'd0, 8'h00);
      run("R6", 1, 0, 0, 0);

      // R8: fallback loop, capacity bit clear though bit 31 set
      wake(); c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h05);
      app(8'h01); op(32'd0, 8'h01); app(8'h01); op(32'd0, 8'h00);
      ocr(8'h00, 32'h80FF_8000);
      run("R8", 1, 0, 0, 0);

      // R8 R10: fallback CMD55 not idle fails attempt, restart without wake
      wake(); c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h04); app(8'h00);
      c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h00); ocr(8'h00, 32'h4000_0000);
      run("R10", 1, 0, 1, 0);

      // R5 R9 R10: bad probe answer, bad register read, success on last attempt
      wake(); c0(8'h01); c8(8'h00);
      c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h00); ocr(8'h01, 32'hC000_0000);
      c0(8'h01); c8(8'h05); app(8'h01); op(32'd0, 8'h00);
      run("R9", 1, 0, 0, 0);

      // R10: all attempts exhausted in the reset loop
      wake();
      for (int a = 0; a < ATTEMPTS; a++) for (int t = 0; t < TRIES; t++) c0(8'hFF);
      run("R10", 0, 1, 0, 0);

      // R7 R11: newer-card op loop limit, then success clears error
      wake(); c0(8'h01); c8(8'h01);
      for (int t = 0; t < TRIES; t++) begin app(8'h01); op(32'h4000_0000, 8'h01); end
      c0(8'h01); c8(8'h01); app(8'h01); op(32'h4000_0000, 8'h00); ocr(8'h00, 32'hC000_0000);
      run("R11", 1, 0, 1, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule